// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Combiner

This block gathers the level-sensitive interrupt pins of every device slot on a PCI-style bus and folds them onto host interrupt lines. Each device slot carries four pins, numbered 0 to 3. The line that a pin reaches is given by a two-way parity rule: the pin index plus the device number, modulo two. Each host line is the OR of every pin that reaches it. Nothing is latched, so a line falls in the same cycle that its last contributing pin is released.

A static mode input picks one of two output arrangements. In legacy mode the four host line outputs are driven separately. In combined mode every line is ORed onto one host interrupt output. The block also decodes a byte-wide interrupt-acknowledge register on the CPU bus. A single-byte read at that address asks the external interrupt controller for a vector and returns it. Any write, or any access wider than one byte, at that address gets an error response, and the controller is not queried.

Top module: `pciirq_router`

## Requirements
- R1: In legacy mode (`cfg_legacy`=1), pin p (0..3) of device slot d reaches host line ((p + d + DEV_FIRST) & 1). Pin p of slot d is bit d*4+p of `dev_irq`.
- R2: Each host line is the combinational OR of all pins that map to it. It stays high while any contributor is high and falls in the same cycle that the last contributor is released.
- R3: In legacy mode, `host_irq[3:2]` are always 0, because the parity rule never selects lines 2 or 3.
- R4: In combined mode (`cfg_legacy`=0), `host_irq[0]` is the OR of every bit of `dev_irq`, and `host_irq[3:1]` are 0.
- R5: A request with `bus_req`=1, `bus_we`=0, `bus_size`=0 (byte) and `bus_addr`=ACK_ADDR (default 0xBFFFFFF0) raises `ic_ack` in the same cycle. In the next cycle the block gives `rsp_valid`=1, `rsp_err`=0, and `rsp_rdata` holds `ic_vector` zero-extended.
- R6: A write, or a read with `bus_size` 1 (halfword) or 2 (word), at ACK_ADDR leaves `ic_ack` at 0. In the next cycle the block gives `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0.
- R7: A request to any other address produces neither `ic_ack` nor a response.
- R8: During and after reset, with no request, `rsp_valid` and `rsp_err` are 0. A response lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_legacy | input | 1 | 1: four separate host lines; 0: single combined line |
| dev_irq | input | NUM_DEV*4 | Level interrupt pins, bit d*4+p is pin p of slot d |
| host_irq | output | 4 | Host interrupt lines |
| bus_req | input | 1 | CPU access request, one cycle per access |
| bus_we | input | 1 | 1 for a write |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Access address |
| ic_ack | output | 1 | Acknowledge query to the interrupt controller |
| ic_vector | input | VEC_W | Vector from the controller, valid while ic_ack is high |
| rsp_valid | output | 1 | Response strobe for an acknowledge-address access |
| rsp_err | output | 1 | Error flag for the response |
| rsp_rdata | output | DATA_W | Read data for the response |

## Verification
The assertions assume that `bus_req` is a single-cycle strobe. They also assume that `ic_vector` is stable when sampled at the edge that ends an `ic_ack` cycle, and that `cfg_legacy` does not change within one sampled cycle. The bench respects all of this. It drives every input at the falling edge, holds each request for exactly one cycle, and sets the vector before it raises the request. It changes the mode only while no request is pending.

// File: rtl/pciirq_pkg.sv
package pciirq_pkg;
  localparam int PINS_PER_DEV = 4;
  localparam int HOST_LINES   = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // parity swizzle: pin index plus device number, keep the low bit
  function automatic logic [1:0] swz_line(input int pin, input int dev);
    return 2'((pin + dev) & 1);
  endfunction
endpackage

// File: rtl/pciirq_swizzle.sv
module pciirq_swizzle
  import pciirq_pkg::*;
#(
  parameter int NUM_DEV   = 8,
  parameter int DEV_FIRST = 0,
  localparam int NPINS    = NUM_DEV * PINS_PER_DEV
) (
  input  logic [NPINS-1:0]      pin_lvl,
  output logic [HOST_LINES-1:0] line_lvl
);
  always_comb begin
    line_lvl = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < PINS_PER_DEV; p++) begin
        if (pin_lvl[d*PINS_PER_DEV + p]) begin
          line_lvl[swz_line(p, d + DEV_FIRST)] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pciirq_combine.sv
module pciirq_combine
  import pciirq_pkg::*;
(
  input  logic                  legacy,
  input  logic [HOST_LINES-1:0] line_lvl,
  output logic [HOST_LINES-1:0] host_lvl
);
  logic any_line;
  assign any_line = |line_lvl;

  always_comb begin
    if (legacy) host_lvl = line_lvl;
    else        host_lvl = {{(HOST_LINES-1){1'b0}}, any_line};
  end
endmodule

// File: rtl/pciirq_ack.sv
module pciirq_ack
  import pciirq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 32'hBFFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ic_ack,
  input  logic [VEC_W-1:0]  ic_vector,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic addr_hit, good_acc, bad_acc;
  assign addr_hit = bus_req && (bus_addr == ACK_ADDR);
  assign good_acc = addr_hit && !bus_we && (bus_size == SZ_BYTE);
  assign bad_acc  = addr_hit && !good_acc;
  assign ic_ack   = good_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= addr_hit;
      rsp_err   <= bad_acc;
      rsp_rdata <= good_acc ? DATA_W'(ic_vector) : '0;
    end
  end
endmodule

// File: rtl/pciirq_router.sv
module pciirq_router
  import pciirq_pkg::*;
#(
  parameter int NUM_DEV   = 8,
  parameter int DEV_FIRST = 0,
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 32'hBFFF_FFF0,
  localparam int NPINS    = NUM_DEV * PINS_PER_DEV
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_legacy,
  input  logic [NPINS-1:0]      dev_irq,
  output logic [HOST_LINES-1:0] host_irq,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [1:0]            bus_size,
  input  logic [ADDR_W-1:0]     bus_addr,
  output logic                  ic_ack,
  input  logic [VEC_W-1:0]      ic_vector,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [DATA_W-1:0]     rsp_rdata
);
  logic [HOST_LINES-1:0] swz_lines;

  pciirq_swizzle #(.NUM_DEV(NUM_DEV), .DEV_FIRST(DEV_FIRST)) u_swz (
    .pin_lvl  (dev_irq),
    .line_lvl (swz_lines)
  );

  pciirq_combine u_cmb (
    .legacy   (cfg_legacy),
    .line_lvl (swz_lines),
    .host_lvl (host_irq)
  );

  pciirq_ack #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .DATA_W(DATA_W), .ACK_ADDR(ACK_ADDR)
  ) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .ic_ack    (ic_ack),
    .ic_vector (ic_vector),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/pciirq_router_chk.sv
module pciirq_router_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 32'hBFFF_FFF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_legacy,
  input logic [NPINS-1:0]  dev_irq,
  input logic [3:0]        host_irq,
  input logic              bus_req,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ic_ack,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata
);
  a_r2_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq == '0) |-> (host_irq == 4'b0));

  a_r3_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legacy |-> (host_irq[3:2] == 2'b00));

  a_r4_single_out: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_legacy |-> (host_irq[3:1] == 3'b000 && host_irq[0] == (|dev_irq)));

  a_r5_ack_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    ic_ack |-> (bus_req && !bus_we && bus_size == 2'd0 && bus_addr == ACK_ADDR));

  a_r5_ack_response: assert property (@(posedge clk) disable iff (!rst_n)
    ic_ack |=> (rsp_valid && !rsp_err));

  a_r6_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0 && !$past(ic_ack)));

  a_r7_rsp_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_req && bus_addr == ACK_ADDR));

  a_r8_err_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
endmodule

bind pciirq_router pciirq_router_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_ADDR(ACK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_legacy(cfg_legacy), .dev_irq(dev_irq),
  .host_irq(host_irq), .bus_req(bus_req), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .ic_ack(ic_ack),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/pciirq_router_test.sv
module pciirq_router_test;
  localparam int ND = 8;
  localparam int NP = ND * 4;
  localparam logic [31:0] ACKA = 32'hBFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_legacy = 1'b1;
  logic [NP-1:0] dev_irq = '0;
  logic [3:0]  host_irq;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_addr = '0;
  logic        ic_ack;
  logic [7:0]  ic_vector = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pciirq_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_legacy(cfg_legacy), .dev_irq(dev_irq),
    .host_irq(host_irq), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .ic_ack(ic_ack),
    .ic_vector(ic_vector), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; checks ic_ack in the request cycle and the response after it
  task automatic access(string req, logic we, logic [1:0] sz, logic [31:0] a,
                        logic exp_ack, logic exp_v, logic exp_e, logic [31:0] exp_d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a;
    #1 chk(req, {31'b0, ic_ack}, {31'b0, exp_ack});
    @(posedge clk); #1;
    chk(req, {30'b0, rsp_valid, rsp_err}, {30'b0, exp_v, exp_e});
    chk(req, rsp_rdata, exp_d);
    @(negedge clk);
    bus_req = 1'b0;
    @(posedge clk); #1;
    chk("R8", {31'b0, rsp_valid}, 32'b0);
  endtask

  task automatic t_reset;
    #1 chk("R8", {30'b0, rsp_valid, rsp_err}, 32'b0);
    chk("R2", {28'b0, host_irq}, 32'b0);
  endtask

  task automatic t_legacy_each_pin;
    cfg_legacy = 1'b1;
    for (int d = 0; d < ND; d++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        dev_irq = '0;
        dev_irq[d*4+p] = 1'b1;
        #1 chk("R1", {28'b0, host_irq}, (((p + d) % 2) == 0) ? 32'h1 : 32'h2);
      end
    end
    @(negedge clk);
    dev_irq = '1;
    #1 chk("R3", {28'b0, host_irq}, 32'h3);
  endtask

  task automatic t_legacy_drop;
    cfg_legacy = 1'b1;
    @(negedge clk);
    dev_irq = '0;
    dev_irq[0] = 1'b1;   // slot 0 pin 0 -> line 0
    dev_irq[5] = 1'b1;   // slot 1 pin 1 -> line 0
    #1 chk("R2", {28'b0, host_irq}, 32'h1);
    dev_irq[0] = 1'b0;
    #1 chk("R2", {28'b0, host_irq}, 32'h1);
    dev_irq[5] = 1'b0;
    #1 chk("R2", {28'b0, host_irq}, 32'h0);
  endtask

  task automatic t_combined;
    @(negedge clk);
    cfg_legacy = 1'b0;
    dev_irq = '0;
    dev_irq[1] = 1'b1;   // maps to line 1 when separate
    #1 chk("R4", {28'b0, host_irq}, 32'h1);
    dev_irq = '0;
    dev_irq[NP-1] = 1'b1;
    #1 chk("R4", {28'b0, host_irq}, 32'h1);
    dev_irq = '1;
    #1 chk("R4", {28'b0, host_irq}, 32'h1);
    dev_irq = '0;
    #1 chk("R4", {28'b0, host_irq}, 32'h0);
    @(negedge clk);
    cfg_legacy = 1'b1;
    dev_irq[1] = 1'b1;
    #1 chk("R3", {28'b0, host_irq}, 32'h2);
    dev_irq = '0;
  endtask

  task automatic t_ack_good;
    ic_vector = 8'h5A;
    access("R5", 1'b0, 2'd0, ACKA, 1'b1, 1'b1, 1'b0, 32'h0000_005A);
    ic_vector = 8'hC3;
    access("R5", 1'b0, 2'd0, ACKA, 1'b1, 1'b1, 1'b0, 32'h0000_00C3);
  endtask

  task automatic t_ack_bad;
    ic_vector = 8'h77;
    access("R6", 1'b1, 2'd0, ACKA, 1'b0, 1'b1, 1'b1, 32'h0);
    access("R6", 1'b0, 2'd1, ACKA, 1'b0, 1'b1, 1'b1, 32'h0);
    access("R6", 1'b0, 2'd2, ACKA, 1'b0, 1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_other_addr;
    access("R7", 1'b0, 2'd0, 32'hBFFF_FFF4, 1'b0, 1'b0, 1'b0, 32'h0);
    access("R7", 1'b0, 2'd0, 32'h3FFF_FFF0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_legacy_each_pin;
    t_legacy_drop;
    t_combined;
    t_ack_good;
    t_ack_bad;
    t_other_addr;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule